// File: doc/BRIEF.md
# Static Memory Write Cycle Generator

This block runs single write transfers on an asynchronous external static memory bus with a 24-bit address and an 8-bit data path. A host raises a request that carries the address, the data byte, a data-timing mode bit and six timing values. Each of the two active-low strobes (chip select and write enable) gets its own setup, pulse and hold count, measured in clock cycles. The block answers with a one-cycle acknowledge in the last cycle of the transfer.

The mode bit picks which strobe sets the data-bus drive window. When the mode bit is 1, the write-enable strobe governs it: the data output enable turns on once the write-enable setup count has elapsed and stays on until the transfer ends. The chip-select strobe has no bearing on it. When the mode bit is 0, the chip-select strobe governs the window in the same way and the write-enable strobe has no bearing on it.

Internally a cycle controller moves between two named states. `CY_IDLE` goes to `CY_BUSY` on an accepted request. `CY_BUSY` goes back to `CY_IDLE` in the acknowledge cycle. Two strobe shapers, one per strobe, step through the phases `PH_IDLE`, `PH_SETUP`, `PH_PULSE`, `PH_HOLD` and `PH_DONE`, with these transitions:

- start: from `PH_IDLE` to `PH_SETUP`, or straight to `PH_PULSE` when the setup count is zero.
- setup expiry: from `PH_SETUP` to `PH_PULSE`.
- pulse expiry: from `PH_PULSE` to `PH_HOLD`, or straight to `PH_DONE` when the hold count is zero.
- hold expiry: from `PH_HOLD` to `PH_DONE`.
- finish: from any phase back to `PH_IDLE`, taken on the acknowledge edge.

Top module: `sram_wr_sequencer`

## Requirements
- R1: After reset, and whenever no transfer is active, `mem_cs_n` and `mem_we_n` are 1, `mem_data_oe` is 0 and `ack` is 0. After reset, `mem_addr` and `mem_data` are 0.
- R2: A request is accepted on a rising edge only when the block is idle and `req` is 1. Requests seen during a transfer are ignored, and each accepted request yields exactly one `ack` pulse.
- R3: Cycle 0 of a transfer is the clock cycle that follows the accepting edge. The transfer lasts L = max(Sw+Pw+Hw, Sc+Pc+Hc) cycles, with pulse values as adjusted by R6. `ack` is 1 only in cycle L-1.
- R4: `mem_we_n` is 0 exactly in transfer cycles Sw to Sw+Pw-1, and 1 in all other cycles.
- R5: `mem_cs_n` is 0 exactly in transfer cycles Sc to Sc+Pc-1, and 1 in all other cycles.
- R6: A setup or hold value of 0 removes that phase. A pulse value of 0 acts as 1, so each strobe is low for at least one cycle of every transfer.
- R7: With mode bit 1, `mem_data_oe` is 1 from transfer cycle Sw through cycle L-1, whatever `mem_cs_n` does.
- R8: With mode bit 0, `mem_data_oe` is 1 from transfer cycle Sc through cycle L-1, whatever `mem_we_n` does.
- R9: `mem_addr` and `mem_data` show the values latched at acceptance, and stay stable through the transfer. Changes on any request input during a transfer have no effect on the transfer in progress.
- R10: If `req` stays 1 across an acknowledge, the next request is accepted after exactly one idle cycle. Its acknowledge then comes L2+1 cycles after the previous one, where L2 is the new transfer's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that times every phase |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Write request |
| req_addr | input | 24 | Target address |
| req_data | input | 8 | Byte to write |
| req_data_by_we | input | 1 | 1: write enable governs data drive; 0: chip select governs it |
| req_we_setup | input | 4 | Write-enable setup cycles |
| req_we_pulse | input | 4 | Write-enable pulse cycles (0 acts as 1) |
| req_we_hold | input | 4 | Write-enable hold cycles |
| req_cs_setup | input | 4 | Chip-select setup cycles |
| req_cs_pulse | input | 4 | Chip-select pulse cycles (0 acts as 1) |
| req_cs_hold | input | 4 | Chip-select hold cycles |
| ack | output | 1 | One-cycle pulse in the last transfer cycle |
| mem_addr | output | 24 | External address bus |
| mem_data | output | 8 | External data value |
| mem_data_oe | output | 1 | Data output buffer enable |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_we_n | output | 1 | Active-low write enable |

## Verification
The assertions assume that the timing inputs are in range for the 4-bit counters. They also assume that the only thing ending a transfer is both shapers reaching their final cycle together, which means the controller never sends the finish signal early. They assume nothing about the host's handshake: the stimulus deliberately keeps `req` high and changes every request field during transfers, and the stated properties must still hold. The bench carries a behavioural per-cycle model that includes zero-valued setup, pulse and hold counts, maximum counts, both mode settings, and back-to-back requests. Every bus output is compared with that model on every clock.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD,
        PH_DONE
    } phase_e;

    typedef enum logic {
        CY_IDLE,
        CY_BUSY
    } cyc_e;

    localparam int STROBE_WE = 0;
    localparam int STROBE_CS = 1;
    localparam int N_STROBES = 2;
endpackage

// File: rtl/wr_strobe_shaper.sv
module wr_strobe_shaper
    import sram_wr_pkg::*;
#(
    parameter int TIME_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              finish,
    input  logic [TIME_W-1:0] setup_i,
    input  logic [TIME_W-1:0] pulse_i,
    input  logic [TIME_W-1:0] hold_i,
    output logic              active_o,
    output logic              drive_o,
    output logic              last_o
);
    localparam logic [TIME_W-1:0] ONE  = TIME_W'(1);
    localparam logic [TIME_W-1:0] ZERO = '0;

    phase_e            phase, phase_n;
    logic [TIME_W-1:0] cnt, cnt_n;
    logic [TIME_W-1:0] pulse_r, hold_r;
    logic [TIME_W-1:0] pulse_eff;

    assign pulse_eff = (pulse_i == ZERO) ? ONE : pulse_i;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= ZERO;
            pulse_r <= ONE;
            hold_r  <= ZERO;
        end else begin
            phase <= phase_n;
            cnt   <= cnt_n;
            if (start && phase == PH_IDLE) begin
                pulse_r <= pulse_eff;
                hold_r  <= hold_i;
            end
        end
    end

    // next phase
    always_comb begin
        phase_n = phase;
        cnt_n   = cnt;
        unique case (phase)
            PH_IDLE: begin
                if (start) begin
                    if (setup_i != ZERO) begin
                        phase_n = PH_SETUP;
                        cnt_n   = setup_i - ONE;
                    end else begin
                        phase_n = PH_PULSE;
                        cnt_n   = pulse_eff - ONE;
                    end
                end
            end
            PH_SETUP: begin
                if (cnt == ZERO) begin
                    phase_n = PH_PULSE;
                    cnt_n   = pulse_r - ONE;
                end else begin
                    cnt_n = cnt - ONE;
                end
            end
            PH_PULSE: begin
                if (cnt == ZERO) begin
                    if (hold_r != ZERO) begin
                        phase_n = PH_HOLD;
                        cnt_n   = hold_r - ONE;
                    end else begin
                        phase_n = PH_DONE;
                    end
                end else begin
                    cnt_n = cnt - ONE;
                end
            end
            PH_HOLD: begin
                if (cnt == ZERO) begin
                    phase_n = PH_DONE;
                end else begin
                    cnt_n = cnt - ONE;
                end
            end
            PH_DONE: begin
                phase_n = PH_DONE;
            end
            default: begin
                phase_n = PH_IDLE;
                cnt_n   = ZERO;
            end
        endcase
        if (finish) begin
            phase_n = PH_IDLE;
            cnt_n   = ZERO;
        end
    end

    // outputs
    always_comb begin
        active_o = 1'b0;
        drive_o  = 1'b0;
        last_o   = 1'b0;
        unique case (phase)
            PH_IDLE:  ;
            PH_SETUP: ;
            PH_PULSE: begin
                active_o = 1'b1;
                drive_o  = 1'b1;
                last_o   = (cnt == ZERO) && (hold_r == ZERO);
            end
            PH_HOLD: begin
                drive_o = 1'b1;
                last_o  = (cnt == ZERO);
            end
            PH_DONE: begin
                drive_o = 1'b1;
                last_o  = 1'b1;
            end
            default: ;
        endcase
    end

    // R4: once finished, a strobe stays finished until the transfer ends
    p_done_sticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE && !finish) |=> (phase == PH_DONE));

    // R7: the drive window never closes before the transfer ends
    p_drive_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_o && !finish) |=> drive_o);

    // R6: every started shaper reaches its pulse phase
    p_setup_to_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SETUP && cnt == ZERO) |=> (phase == PH_PULSE));
endmodule

// File: rtl/wr_cycle_ctrl.sv
module wr_cycle_ctrl
    import sram_wr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              mode_i,
    input  logic              we_last,
    input  logic              cs_last,
    output logic              accept_o,
    output logic              ack_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              mode_o
);
    cyc_e state, state_n;

    // state register and latched request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= CY_IDLE;
            addr_o <= '0;
            data_o <= '0;
            mode_o <= 1'b0;
        end else begin
            state <= state_n;
            if (accept_o) begin
                addr_o <= addr_i;
                data_o <= data_i;
                mode_o <= mode_i;
            end
        end
    end

    // outputs and next state
    always_comb begin
        state_n  = state;
        accept_o = 1'b0;
        ack_o    = 1'b0;
        busy_o   = 1'b0;
        unique case (state)
            CY_IDLE: begin
                if (req) begin
                    accept_o = 1'b1;
                    state_n  = CY_BUSY;
                end
            end
            CY_BUSY: begin
                busy_o = 1'b1;
                if (we_last && cs_last) begin
                    ack_o   = 1'b1;
                    state_n = CY_IDLE;
                end
            end
            default: state_n = CY_IDLE;
        endcase
    end

    p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    p_no_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !accept_o);

    p_latch_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ack_o) |=> (busy_o && $stable(addr_o) && $stable(data_o)));
endmodule

// File: rtl/sram_wr_sequencer.sv
module sram_wr_sequencer
    import sram_wr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int TIME_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_data_by_we,
    input  logic [TIME_W-1:0] req_we_setup,
    input  logic [TIME_W-1:0] req_we_pulse,
    input  logic [TIME_W-1:0] req_we_hold,
    input  logic [TIME_W-1:0] req_cs_setup,
    input  logic [TIME_W-1:0] req_cs_pulse,
    input  logic [TIME_W-1:0] req_cs_hold,
    output logic              ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              mem_data_oe,
    output logic              mem_cs_n,
    output logic              mem_we_n
);
    logic accept, busy, mode;
    logic [TIME_W-1:0] setup_a [N_STROBES];
    logic [TIME_W-1:0] pulse_a [N_STROBES];
    logic [TIME_W-1:0] hold_a  [N_STROBES];
    logic [N_STROBES-1:0] act, drv, lst;

    assign setup_a[STROBE_WE] = req_we_setup;
    assign pulse_a[STROBE_WE] = req_we_pulse;
    assign hold_a[STROBE_WE]  = req_we_hold;
    assign setup_a[STROBE_CS] = req_cs_setup;
    assign pulse_a[STROBE_CS] = req_cs_pulse;
    assign hold_a[STROBE_CS]  = req_cs_hold;

    wr_cycle_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .addr_i   (req_addr),
        .data_i   (req_data),
        .mode_i   (req_data_by_we),
        .we_last  (lst[STROBE_WE]),
        .cs_last  (lst[STROBE_CS]),
        .accept_o (accept),
        .ack_o    (ack),
        .busy_o   (busy),
        .addr_o   (mem_addr),
        .data_o   (mem_data),
        .mode_o   (mode)
    );

    for (genvar g = 0; g < N_STROBES; g++) begin : g_strobe
        wr_strobe_shaper #(.TIME_W(TIME_W)) u_shaper (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (accept),
            .finish   (ack),
            .setup_i  (setup_a[g]),
            .pulse_i  (pulse_a[g]),
            .hold_i   (hold_a[g]),
            .active_o (act[g]),
            .drive_o  (drv[g]),
            .last_o   (lst[g])
        );
    end

    assign mem_we_n    = ~act[STROBE_WE];
    assign mem_cs_n    = ~act[STROBE_CS];
    assign mem_data_oe = busy & (mode ? drv[STROBE_WE] : drv[STROBE_CS]);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_cs_n && mem_we_n && !mem_data_oe && !ack));

    p_oe_until_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_data_oe && !ack) |=> mem_data_oe);

    p_ack_ends_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !busy);
endmodule

// File: tb/sram_wr_sequencer_tb.sv
module sram_wr_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [23:0]   req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          req_mode = 1'b0;
    logic [TW-1:0] ws = '0, wp = '0, wh = '0, cs = '0, cp = '0, ch = '0;
    logic          ack, oe, cs_n, we_n;
    logic [23:0]   addr;
    logic [7:0]    data;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_wr_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
        .req_data(req_data), .req_data_by_we(req_mode),
        .req_we_setup(ws), .req_we_pulse(wp), .req_we_hold(wh),
        .req_cs_setup(cs), .req_cs_pulse(cp), .req_cs_hold(ch),
        .ack(ack), .mem_addr(addr), .mem_data(data), .mem_data_oe(oe),
        .mem_cs_n(cs_n), .mem_we_n(we_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int effp(input int p);
        return (p == 0) ? 1 : p;
    endfunction

    // behavioural reference model
    int          m_busy = 0, m_t = 0, m_len = 0, m_mode = 0;
    int          m_sw, m_pw, m_hw, m_sc, m_pc, m_hc;
    logic [23:0] m_addr = '0;
    logic [7:0]  m_data = '0;
    int          m_accepts = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_t = 0; m_addr = '0; m_data = '0;
        end else if (m_busy != 0) begin
            if (m_t == m_len - 1) m_busy = 0;
            else m_t++;
        end else if (req) begin
            m_addr = req_addr; m_data = req_data; m_mode = int'(req_mode);
            m_sw = int'(ws); m_pw = effp(int'(wp)); m_hw = int'(wh);
            m_sc = int'(cs); m_pc = effp(int'(cp)); m_hc = int'(ch);
            m_len = m_sw + m_pw + m_hw;
            if (m_sc + m_pc + m_hc > m_len) m_len = m_sc + m_pc + m_hc;
            m_busy = 1; m_t = 0; m_accepts++;
        end
    end

    // per-clock comparison, plus observations for directed checks
    int cyc = 0, n_ack = 0, ack_cyc = 0, prev_ack_cyc = 0;
    int we_low = 0, last_we_low = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            bit e_we, e_cs, e_oe, e_ack;
            e_we = 0; e_cs = 0; e_oe = 0; e_ack = 0;
            if (m_busy != 0) begin
                e_we  = (m_t >= m_sw) && (m_t < m_sw + m_pw);
                e_cs  = (m_t >= m_sc) && (m_t < m_sc + m_pc);
                e_oe  = (m_mode != 0) ? (m_t >= m_sw) : (m_t >= m_sc);
                e_ack = (m_t == m_len - 1);
                chk(we_n == !e_we, "R4 we_n", int'(we_n), int'(!e_we));
                chk(cs_n == !e_cs, "R5 cs_n", int'(cs_n), int'(!e_cs));
                chk(oe == e_oe, (m_mode != 0) ? "R7 oe" : "R8 oe", int'(oe), int'(e_oe));
                chk(ack == e_ack, "R3 ack", int'(ack), int'(e_ack));
            end else begin
                chk(we_n && cs_n && !oe && !ack, "R1 idle outputs",
                    int'({we_n, cs_n, oe, ack}), 12);
            end
            chk(addr == m_addr, "R9 addr", int'(addr), int'(m_addr));
            chk(data == m_data, "R9 data", int'(data), int'(m_data));
            if (!we_n) we_low++;
            if (ack) begin
                n_ack++;
                prev_ack_cyc = ack_cyc;
                ack_cyc = cyc;
                last_we_low = we_low;
                we_low = 0;
            end
        end
    end

    task automatic do_write(input logic [23:0] a, input logic [7:0] d, input bit md,
                            input int sw, input int pw, input int hw,
                            input int sc, input int pc, input int hc, input bit keep);
        @(negedge clk);
        req_addr = a; req_data = d; req_mode = md;
        ws = TW'(sw); wp = TW'(pw); wh = TW'(hw);
        cs = TW'(sc); cp = TW'(pc); ch = TW'(hc);
        req = 1'b1;
        @(negedge clk);
        // R9/R2: scramble every request field while the transfer runs
        req_addr = ~a; req_data = ~d; req_mode = ~md;
        ws = TW'(15 - sw); wp = TW'(7); wh = TW'(15 - hw);
        cs = TW'(3); cp = TW'(15 - pc); ch = TW'(9);
        for (int i = 0; i < 100 && !ack; i++) @(negedge clk);
        if (!keep) req = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs while in reset
        chk(we_n && cs_n && !oe && !ack && addr == 0 && data == 0, "R1 reset",
            int'({we_n, cs_n, oe, ack}), 12);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        do_write(24'h123456, 8'hA5, 1'b1, 2, 3, 1, 1, 5, 2, 1'b0);
        do_write(24'hABCDEF, 8'h3C, 1'b0, 2, 3, 1, 1, 5, 2, 1'b0);
        // R6: all zero timings give a single-cycle transfer with one low cycle
        do_write(24'h000001, 8'h01, 1'b1, 0, 0, 0, 0, 0, 0, 1'b0);
        @(posedge clk);
        chk(last_we_low == 1, "R6 pulse zero acts as one", last_we_low, 1);
        do_write(24'hFF00FF, 8'h80, 1'b0, 4, 2, 3, 0, 1, 0, 1'b0);
        do_write(24'hFFFFFF, 8'hFF, 1'b1, 15, 15, 15, 15, 15, 15, 1'b0);
        @(posedge clk);
        chk(last_we_low == 15, "R4 long pulse", last_we_low, 15);
        // R10: back-to-back with req held high
        do_write(24'h010203, 8'h11, 1'b1, 1, 2, 0, 0, 4, 1, 1'b1);
        do_write(24'h040506, 8'h22, 1'b0, 0, 1, 2, 3, 2, 0, 1'b0);
        @(posedge clk);
        chk(ack_cyc - prev_ack_cyc == 6, "R10 ack spacing", ack_cyc - prev_ack_cyc, 6);
        for (int k = 0; k < 25; k++) begin
            do_write(24'($urandom), 8'($urandom), 1'($urandom),
                     $urandom_range(0, 6), $urandom_range(0, 6), $urandom_range(0, 6),
                     $urandom_range(0, 6), $urandom_range(0, 6), $urandom_range(0, 6),
                     k[0]);
        end
        req = 1'b0;
        repeat (5) @(negedge clk);
        // R2: one acknowledge per accepted request, none for ignored ones
        chk(n_ack == m_accepts, "R2 ack count", n_ack, m_accepts);
        chk(n_ack == 32, "R2 accepted count", n_ack, 32);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule